// File: doc/BRIEF.md
# Double-Rank Crosspoint Routing Controller

This block holds the connection map of a nonblocking digital crosspoint with 33 data inputs and 17 data outputs, and applies it to the data path. A host reaches it through a small parallel port. The port has an active-low select, write, apply and read strobe, a 5-bit row address and a 7-bit bidirectional data bus. Each output owns one row. A host write lands only in a staging copy of that row. An apply strobe then moves all 17 staged rows into the live copy on one clock edge, so every output switches together.

Each live row holds an input index in bits 5:0 and an output enable in bit 6. Each output is a registered selector over the 33 inputs. A disabled output is held at 0, which lets outputs of several such arrays share a bus. Reading a row returns its live value and never its staged value. An asynchronous reset clears only the live enable bits, and leaves the staged rows and the live indices as they were.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: A clock edge with sel_n=0 and wr_n=0 loads dq[6:0] into the staging row addressed by addr. No live row and no output changes because of it.
- R2: A clock edge with sel_n=0 and upd_n=0 copies all 17 staging rows into the live rows together. The new routing appears at dout from the following clock edge.
- R3: With sel_n=1, wr_n and upd_n have no effect on any row.
- R4: While sel_n=0 and rd_n=0, dq is driven with the live row at addr. The format is bit 6 for enable and bits 5:0 for input index.
- R5: Writes to addr values 17 to 31 change no row. Reading those addresses returns 7'h00.
- R6: An output whose live enable is 0 drives 0. An output that is enabled with an index above 32 also drives 0.
- R7: When rst_n goes low, every live enable clears and every dout bit goes to 0 without waiting for a clock edge. Staged rows and live indices are kept, so a later apply restores them.
- R8: dout[o] equals the selected input as sampled at the previous clock edge. This gives one cycle of latency and no combinational path from din.
- R9: Several outputs may select the same input at once, and each follows that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the live enables |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low staging write strobe |
| upd_n | input | 1 | Active-low apply strobe |
| rd_n | input | 1 | Active-low live readback enable |
| addr | input | 5 | Output row address |
| dq | inout | 7 | Row data: written by the host, driven by the block on readback |
| din | input | 33 | Data inputs of the crosspoint |
| dout | output | 17 | Registered data outputs |

## Verification
The routing is tested with several input patterns: all ones, a single one on input 7, a single one on input 32, and an alternating pattern. The all-ones and single-one patterns show which outputs are enabled and which input each one is tied to. The alternating pattern catches an index that is off by one. Each pattern is applied once before the apply strobe and again after it. The first pass shows that staged rows do not act early, and the second shows that all rows switch together. Mixed table rows are also applied: disabled, enabled with an out-of-range index, and writes to unused addresses. These separate the enable, the range guard and the address decode.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
   localparam int DEF_NUM_IN  = 33;
   localparam int DEF_NUM_OUT = 17;
   localparam int DEF_ADDR_W  = 5;

   // bits needed to index n items (at least one)
   function automatic int sel_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/xbar_stage_bank.sv
module xbar_stage_bank #(
   parameter int NUM_OUT = 17,
   parameter int ROW_W   = 7,
   parameter int ADDR_W  = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_stb,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [ROW_W-1:0]                wr_data,
   input  logic                            upd_stb,
   output logic [NUM_OUT-1:0][ROW_W-1:0]   stage_q,
   output logic [NUM_OUT-1:0][ROW_W-1:0]   act_q
);
   localparam int IDX_W = ROW_W - 1;

   for (genvar r = 0; r < NUM_OUT; r++) begin : g_row
      logic [ROW_W-1:0] stg;
      logic [IDX_W-1:0] idx;
      logic             en;
      logic             hit;

      // full-width compare: addresses past the last row match nothing
      assign hit = wr_stb && (wr_addr == ADDR_W'(r));

      always_ff @(posedge clk) begin
         if (hit) stg <= wr_data;
      end

      always_ff @(posedge clk) begin
         if (upd_stb) idx <= stg[IDX_W-1:0];
      end

      // only the enable is reset; the index survives a reset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       en <= 1'b0;
         else if (upd_stb) en <= stg[ROW_W-1];
      end

      assign stage_q[r] = stg;
      assign act_q[r]   = {en, idx};
   end
endmodule

// File: rtl/xbar_route_lane.sv
module xbar_route_lane #(
   parameter int NUM_IN = 33,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] din,
   input  logic              en,
   input  logic [IDX_W-1:0]  idx,
   output logic              q
);
   logic pick;

   if (NUM_IN == (1 << IDX_W)) begin : g_full
      // every index code names a real input
      assign pick = din[idx];
   end else begin : g_part
      // codes past the last input select nothing
      always_comb begin
         pick = 1'b0;
         for (int i = 0; i < NUM_IN; i++) begin
            if (idx == IDX_W'(i)) pick = din[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= en & pick;
   end
endmodule

// File: rtl/xbar_readback.sv
module xbar_readback #(
   parameter int NUM_OUT = 17,
   parameter int ROW_W   = 7,
   parameter int ADDR_W  = 5
) (
   input  logic [NUM_OUT-1:0][ROW_W-1:0] act_q,
   input  logic [ADDR_W-1:0]             addr,
   output logic [ROW_W-1:0]              rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][ROW_W-1:0] pad;

   for (genvar a = 0; a < DEPTH; a++) begin : g_pad
      if (a < NUM_OUT) begin : g_live
         assign pad[a] = act_q[a];
      end else begin : g_void
         assign pad[a] = '0;
      end
   end

   assign rd_data = pad[addr];
endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
   import xbar_cfg_pkg::*;
#(
   parameter  int NUM_IN  = DEF_NUM_IN,
   parameter  int NUM_OUT = DEF_NUM_OUT,
   parameter  int ADDR_W  = DEF_ADDR_W,
   localparam int IDX_W   = sel_width(NUM_IN),
   localparam int ROW_W   = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_n,
   input  logic               wr_n,
   input  logic               upd_n,
   input  logic               rd_n,
   input  logic [ADDR_W-1:0]  addr,
   inout  wire  [ROW_W-1:0]   dq,
   input  logic [NUM_IN-1:0]  din,
   output logic [NUM_OUT-1:0] dout
);
   if (NUM_OUT > (1 << ADDR_W)) begin : g_bad_addr
      $error("xbar_cfg_ctrl: ADDR_W too narrow for NUM_OUT");
   end
   if (NUM_IN < 2) begin : g_bad_in
      $error("xbar_cfg_ctrl: NUM_IN must be at least 2");
   end
   if (NUM_OUT < 1) begin : g_bad_out
      $error("xbar_cfg_ctrl: NUM_OUT must be at least 1");
   end

   logic                          wr_stb;
   logic                          upd_stb;
   logic                          rd_oe;
   logic [ROW_W-1:0]              rd_data;
   logic [NUM_OUT-1:0][ROW_W-1:0] stage_q;
   logic [NUM_OUT-1:0][ROW_W-1:0] act_q;

   assign wr_stb  = !sel_n && !wr_n;
   assign upd_stb = !sel_n && !upd_n;
   assign rd_oe   = !sel_n && !rd_n;

   xbar_stage_bank #(
      .NUM_OUT (NUM_OUT),
      .ROW_W   (ROW_W),
      .ADDR_W  (ADDR_W)
   ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_addr (addr),
      .wr_data (dq),
      .upd_stb (upd_stb),
      .stage_q (stage_q),
      .act_q   (act_q)
   );

   xbar_readback #(
      .NUM_OUT (NUM_OUT),
      .ROW_W   (ROW_W),
      .ADDR_W  (ADDR_W)
   ) rb_i (
      .act_q   (act_q),
      .addr    (addr),
      .rd_data (rd_data)
   );

   assign dq = rd_oe ? rd_data : {ROW_W{1'bz}};

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_lane
      xbar_route_lane #(
         .NUM_IN (NUM_IN),
         .IDX_W  (IDX_W)
      ) lane_i (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (din),
         .en    (act_q[o][ROW_W-1]),
         .idx   (act_q[o][IDX_W-1:0]),
         .q     (dout[o])
      );
   end
endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk #(
   parameter int NUM_OUT = 17,
   parameter int ROW_W   = 7,
   parameter int ADDR_W  = 5
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          sel_n,
   input logic                          upd_n,
   input logic                          rd_n,
   input logic [ADDR_W-1:0]             addr,
   input logic [ROW_W-1:0]              dq,
   input logic [NUM_OUT-1:0]            dout,
   input logic [NUM_OUT-1:0][ROW_W-1:0] stage_q,
   input logic [NUM_OUT-1:0][ROW_W-1:0] act_q
);
   logic [NUM_OUT-1:0] en_vec;
   always_comb begin
      for (int o = 0; o < NUM_OUT; o++) en_vec[o] = act_q[o][ROW_W-1];
   end

   // R1 / R3: live rows move only on an apply with select
   a_r1_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n || upd_n) |=> $stable(act_q));

   // R2: apply copies every staged row at once
   a_r2_apply_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !upd_n) |=> (act_q == $past(stage_q)));

   // R6: with no output enabled, every output is idle one edge later
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec == '0) |=> (dout == '0));

   // R5: unused addresses read as zero
   a_r5_void_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !rd_n && (int'(addr) >= NUM_OUT)) |-> (dq == '0));

   // R7: while reset is held, enables and outputs are clear
   a_r7_reset_off: assert property (@(posedge clk)
      !rst_n |-> (dout == '0 && en_vec == '0));
endmodule

bind xbar_cfg_ctrl xbar_cfg_chk #(
   .NUM_OUT (NUM_OUT),
   .ROW_W   (ROW_W),
   .ADDR_W  (ADDR_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_n   (sel_n),
   .upd_n   (upd_n),
   .rd_n    (rd_n),
   .addr    (addr),
   .dq      (dq),
   .dout    (dout),
   .stage_q (stage_q),
   .act_q   (act_q)
);

// File: tb/xbar_cfg_ctrl_tb_top.sv
module xbar_cfg_ctrl_tb_top;
   localparam int NI = 33;
   localparam int NO = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          sel_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1, rd_n = 1'b1;
   logic [4:0]    addr = '0;
   logic [6:0]    dq_drv = '0;
   logic          dq_oe = 1'b0;
   logic [NI-1:0] din = '0;
   logic [NO-1:0] dout;
   wire  [6:0]    dq;

   assign dq = dq_oe ? dq_drv : 7'bz;

   always #5 clk = ~clk;

   xbar_cfg_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .upd_n(upd_n),
      .rd_n(rd_n), .addr(addr), .dq(dq), .din(din), .dout(dout)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [6:0] stg_m [NO];
   logic [6:0] act_m [NO];

   typedef struct packed {
      logic [4:0] a;
      logic [6:0] d;
      logic [6:0] rb;
   } vec_t;

   localparam vec_t TBL [7] = '{
      '{a:5'd3,  d:7'h47, rb:7'h47},
      '{a:5'd16, d:7'h60, rb:7'h60},
      '{a:5'd5,  d:7'h21, rb:7'h21},
      '{a:5'd9,  d:7'h61, rb:7'h61},
      '{a:5'd20, d:7'h45, rb:7'h00},
      '{a:5'd0,  d:7'h40, rb:7'h40},
      '{a:5'd31, d:7'h7F, rb:7'h00}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NO-1:0] model_out(input logic [NI-1:0] v);
      logic [NO-1:0] r;
      for (int o = 0; o < NO; o++) begin
         r[o] = (act_m[o][6] && act_m[o][5:0] < 6'd33) ? v[act_m[o][5:0]] : 1'b0;
      end
      return r;
   endfunction

   task automatic write_row(input logic [4:0] a, input logic [6:0] d);
      @(negedge clk);
      sel_n = 0; wr_n = 0; addr = a; dq_drv = d; dq_oe = 1;
      @(negedge clk);
      sel_n = 1; wr_n = 1; dq_oe = 0;
      if (a < 5'd17) stg_m[a] = d;
   endtask

   task automatic apply_all();
      @(negedge clk);
      sel_n = 0; upd_n = 0;
      @(negedge clk);
      sel_n = 1; upd_n = 1;
      for (int i = 0; i < NO; i++) act_m[i] = stg_m[i];
   endtask

   task automatic read_row(input logic [4:0] a, output logic [6:0] d);
      @(negedge clk);
      sel_n = 0; rd_n = 0; addr = a;
      #1 d = dq;
      sel_n = 1; rd_n = 1;
   endtask

   task automatic drive_and_check(input logic [NI-1:0] v, input string tag);
      logic [NO-1:0] prev;
      @(negedge clk);
      prev = dout;
      din = v;
      #1 check({"R8 no combinational path ", tag}, 64'(dout), 64'(prev));
      @(negedge clk);
      check({"R2/R6 routing ", tag}, 64'(dout), 64'(model_out(v)));
   endtask

   initial begin
      logic [6:0] rb;
      for (int i = 0; i < NO; i++) begin stg_m[i] = '0; act_m[i] = '0; end
      #1 rst_n = 0;
      repeat (3) @(negedge clk);
      check("R7 reset state dout", 64'(dout), 64'h0);
      rst_n = 1;

      for (int i = 0; i < NO; i++) write_row(5'(i), 7'h00);
      apply_all();

      // main routing: outputs 0..15 to input 7, output 16 to input 32
      for (int i = 0; i < 16; i++) write_row(5'(i), 7'h47);
      write_row(5'd16, 7'h60);
      din = '1;
      @(negedge clk);
      @(negedge clk);
      check("R1 staged rows not yet live (dout)", 64'(dout), 64'h0);
      read_row(5'd0, rb);
      check("R1 readback shows live not staged", 64'(rb), 64'h00);
      apply_all();

      drive_and_check('1, "all ones");
      drive_and_check(33'h0_0000_0080, "only input 7");
      check("R9 sixteen outputs share input 7", 64'(dout), 64'h0FFFF);
      drive_and_check(33'h1_0000_0000, "only input 32");
      check("R2 output 16 follows input 32", 64'(dout), 64'h10000);
      drive_and_check(33'h1_5555_5555, "alternating");

      for (int i = 0; i < NO; i++) begin
         read_row(5'(i), rb);
         check($sformatf("R4 readback row %0d", i), 64'(rb), 64'(act_m[i]));
      end

      // R3: strobes without select do nothing
      @(negedge clk);
      sel_n = 1; wr_n = 0; upd_n = 0; addr = 5'd0; dq_drv = 7'h00; dq_oe = 1;
      @(negedge clk);
      wr_n = 1; upd_n = 1; dq_oe = 0;
      read_row(5'd0, rb);
      check("R3 live row kept without select", 64'(rb), 64'h47);
      apply_all();
      read_row(5'd0, rb);
      check("R3 staged row kept without select", 64'(rb), 64'h47);

      // table walk: mixed rows and unused addresses
      foreach (TBL[k]) write_row(TBL[k].a, TBL[k].d);
      apply_all();
      foreach (TBL[k]) begin
         read_row(TBL[k].a, rb);
         check($sformatf("R4/R5 table readback addr %0d", TBL[k].a), 64'(rb), 64'(TBL[k].rb));
      end
      for (int i = 0; i < NO; i++) begin
         read_row(5'(i), rb);
         check($sformatf("R5 rows intact after void writes %0d", i), 64'(rb), 64'(act_m[i]));
      end
      drive_and_check(33'h1_FFFF_FFFF, "table all ones");
      check("R6 disabled and out-of-range outputs idle", 64'(dout & 17'h00220), 64'h0);
      drive_and_check(33'h0_0000_0081, "inputs 0 and 7");

      // R7: asynchronous reset mid-cycle
      @(negedge clk);
      #2 rst_n = 0;
      #1 check("R7 outputs clear without clock", 64'(dout), 64'h0);
      read_row(5'd3, rb);
      check("R7 index kept, enable cleared", 64'(rb), 64'h07);
      for (int i = 0; i < NO; i++) act_m[i][6] = 1'b0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R7 outputs stay idle after release", 64'(dout), 64'h0);
      apply_all();
      read_row(5'd3, rb);
      check("R7 staged row restored by apply", 64'(rb), 64'h47);
      drive_and_check(33'h0_0000_0080, "after reset");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      finished = 1'b1;
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule